// File: doc/BRIEF.md
# Trailer-Terminated Packet Delineator

The block takes a stream that is already aligned to byte boundaries, one byte per cycle in which `in_valid` is high. Each packet is four bytes long: three payload bytes, least significant first, followed by a closing marker byte of value 0x06. Filler bytes of value 0xA3 may sit between packets for any length of time. Payload bytes may take any value, including the marker and filler values. Because the marker comes last, the block keeps the most recent four bytes in a shift register. When a marker is accepted, the three older bytes are handed out together as one 24-bit word.

A sequencing machine decides when a marker may be accepted. It has four named states. `ST_DATA0`, `ST_DATA1` and `ST_DATA2` each consume one byte without testing it. `ST_HUNT` tests every new byte. The transitions are:
- Reset goes to `ST_DATA0`.
- Each new byte moves `ST_DATA0` to `ST_DATA1`, `ST_DATA1` to `ST_DATA2`, and `ST_DATA2` to `ST_HUNT`.
- In `ST_HUNT`, a marker byte is accepted and the machine returns to `ST_DATA0`. Any other byte keeps it in `ST_HUNT`.

This forced three-byte blanking after each accepted marker stops marker-valued payload bytes from being taken as packet ends. It keeps alignment when there are no filler bytes between packets. Filler gaps are absorbed as long as no payload byte looks like a marker.

The machine tests the newest stage of the shift register in the cycle after that byte is shifted in. An accepted marker loads the capture register on the next edge. `out_valid` is therefore high for one cycle, two clock edges after the edge that took in the marker.

Top module: `pkt_trailer_delin`

## Requirements
- R1: While `rst` is high, and immediately after reset, `out_valid` is 0 and `out_data` is 0. The first three valid bytes after reset are never tested as a marker, whatever their value.
- R2: In `ST_HUNT`, a valid byte equal to 0x06 is accepted. Two clock edges after the edge that took it in, `out_valid` is 1 and `out_data` holds the three preceding valid bytes. The oldest byte is in bits 7:0, the next in bits 15:8 and the newest in bits 23:16.
- R3: `out_valid` is high for exactly one cycle per accepted marker. `out_data` keeps its value until the next accepted marker.
- R4: After an accepted marker, the next three valid bytes are never accepted, even when they equal 0x06.
- R5: In `ST_HUNT`, any valid byte other than 0x06, including filler 0xA3, keeps the machine hunting. A gap of any length produces no output.
- R6: A cycle with `in_valid` low neither shifts the pipeline nor advances the machine. The value on `in_byte` in that cycle has no effect.
- R7: A stream of back-to-back packets with no filler between them is delineated correctly, even when payload bytes equal 0x06.
- R8: A stream with filler gaps of varying length between packets is delineated correctly when no payload byte equals 0x06.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is present on `in_byte` this cycle |
| in_byte | input | 8 | Incoming stream byte |
| out_valid | output | 1 | One-cycle pulse: a packet was captured |
| out_data | output | 24 | Captured payload, oldest byte in bits 7:0 |

## Verification
Directed patterns check the behaviour that random traffic rarely hits:
- payloads made entirely of marker bytes right after reset, which separates correct blanking from early acceptance;
- a known payload 0x332211, which exposes any byte-order swap;
- long filler runs and payloads of filler value, which show that hunting absorbs gaps;
- `in_valid` bubbles carrying marker values on `in_byte`, which show that stall cycles are ignored.

Two seeded random streams cover the two regimes in which alignment can be kept. The first has back-to-back packets whose payloads are often 0x06, which fails if blanking after a marker is short or missing. The second has random filler gaps with marker-free payloads, which fails if hunting does not hold its state across idle bytes. Each stream is compared packet by packet against an expected queue built from the generated packets, so any extra, missing or misaligned output is caught.

// File: rtl/pkt_delin_pkg.sv
package pkt_delin_pkg;

    // payload bytes per packet; the marker follows them
    localparam int DATA_BYTES = 3;
    localparam int PKT_BYTES  = DATA_BYTES + 1;

    typedef enum logic [1:0] {
        ST_DATA0,
        ST_DATA1,
        ST_DATA2,
        ST_HUNT
    } seq_state_t;

endpackage

// File: rtl/pkt_byte_pipe.sv
module pkt_byte_pipe #(
    parameter  int BYTE_W = 8,
    parameter  int DEPTH  = 4,
    localparam int VEC_W  = BYTE_W * DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [BYTE_W-1:0] din,
    output logic [VEC_W-1:0]  stages,
    output logic              fresh
);

    // stage 0 is the newest byte, stage DEPTH-1 the oldest
    logic [BYTE_W-1:0] st_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst)
                        st_q[i] <= '0;
                    else if (shift_en)
                        st_q[i] <= din;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst)
                        st_q[i] <= '0;
                    else if (shift_en)
                        st_q[i] <= st_q[i-1];
                end
            end
            assign stages[i*BYTE_W +: BYTE_W] = st_q[i];
        end
    endgenerate

    // marks the cycle in which stage 0 holds a byte not yet examined
    always_ff @(posedge clk) begin
        if (rst)
            fresh <= 1'b0;
        else
            fresh <= shift_en;
    end

    AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(stages)); // R6

endmodule

// File: rtl/pkt_seq_fsm.sv
module pkt_seq_fsm
    import pkt_delin_pkg::*;
#(
    parameter int                BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] MARK_BYTE = 8'h06
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [BYTE_W-1:0] newest,
    output logic              accept
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       is_mark;

    assign is_mark = (newest == MARK_BYTE);

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_DATA0;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                ST_DATA0: state_d = ST_DATA1;
                ST_DATA1: state_d = ST_DATA2;
                ST_DATA2: state_d = ST_HUNT;
                ST_HUNT:  state_d = is_mark ? ST_DATA0 : ST_HUNT;
            endcase
        end
    end

    always_comb begin
        accept = step && (state_q == ST_HUNT) && is_mark;
    end

    AST_BLANK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> (state_q == ST_DATA0)); // R4
    AST_STALL_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state_q)); // R6
    AST_HUNT_ABSORBS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HUNT && step && !is_mark) |=> (state_q == ST_HUNT)); // R5

endmodule

// File: rtl/pkt_capture_reg.sv
module pkt_capture_reg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= load;
            if (load)
                dout <= din;
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid); // R3
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(dout)); // R3

endmodule

// File: rtl/pkt_trailer_delin.sv
module pkt_trailer_delin
    import pkt_delin_pkg::*;
#(
    parameter  int                BYTE_W    = 8,
    parameter  logic [BYTE_W-1:0] MARK_BYTE = 8'h06,
    localparam int                OUT_W     = DATA_BYTES * BYTE_W,
    localparam int                PIPE_W    = PKT_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);

    logic [PIPE_W-1:0] stages;
    logic              fresh;
    logic              accept;
    logic [OUT_W-1:0]  cap_din;

    pkt_byte_pipe #(
        .BYTE_W (BYTE_W),
        .DEPTH  (PKT_BYTES)
    ) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .din      (in_byte),
        .stages   (stages),
        .fresh    (fresh)
    );

    pkt_seq_fsm #(
        .BYTE_W    (BYTE_W),
        .MARK_BYTE (MARK_BYTE)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .step   (fresh),
        .newest (stages[BYTE_W-1:0]),
        .accept (accept)
    );

    // oldest stage goes to the least significant byte of the word
    generate
        for (genvar k = 0; k < DATA_BYTES; k++) begin : g_order
            assign cap_din[k*BYTE_W +: BYTE_W] =
                stages[(PKT_BYTES-1-k)*BYTE_W +: BYTE_W];
        end
    endgenerate

    pkt_capture_reg #(
        .W (OUT_W)
    ) u_cap (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .din   (cap_din),
        .dout  (out_data),
        .valid (out_valid)
    );

    AST_OUT_FOLLOWS_MARKER: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && (in_byte == MARK_BYTE), 2)); // R2

endmodule

// File: tb/pkt_trailer_delin_tb_top.sv
module pkt_trailer_delin_tb_top;

    localparam logic [7:0] MARK = 8'h06;
    localparam logic [7:0] FILL = 8'hA3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic [23:0] out_data;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [23:0] expq[$];
    string       cur_req = "R2";
    logic [23:0] last_pkt = 24'h0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    pkt_trailer_delin dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // every captured packet is matched against the generated stream
    always @(negedge clk) begin
        logic [23:0] e;
        if (!rst && out_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R4", "unexpected packet", out_data, 24'h0);
            end else begin
                e = expq.pop_front();
                chk(out_data == e, cur_req, "packet", out_data, e);
            end
        end
    end

    function automatic logic [7:0] rnd_nomark();
        logic [7:0] b;
        do b = 8'($urandom); while (b == MARK);
        return b;
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic stall(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = b;
    endtask

    task automatic send_pkt(input logic [23:0] d);
        send(d[7:0]);
        send(d[15:8]);
        send(d[23:16]);
        expq.push_back(d);
        last_pkt = d;
        send(MARK);
    endtask

    task automatic flush(input string req);
        stall(8'h00);
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, req, "packets still pending",
            24'(expq.size()), 24'h0);
        expq.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", 24'(out_valid), 24'h0);
        chk(out_data == 24'h0, "R1", "out_data in reset", out_data, 24'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 24'(out_valid), 24'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1: three marker-valued bytes after reset are blanked
        cur_req = "R1";
        do_reset();
        send_pkt(24'h060606);
        flush("R1");

        // R2: byte order of the captured word
        cur_req = "R2";
        do_reset();
        send_pkt(24'h332211);
        send_pkt(24'hA30600);
        flush("R2");

        // R3: one-cycle pulse, data held through filler
        cur_req = "R3";
        do_reset();
        send_pkt(24'h5A5A01);
        flush("R3");
        for (int i = 0; i < 6; i++) begin
            send(FILL);
            @(negedge clk);
            in_valid = 1'b0;
            chk(out_valid == 1'b0, "R3", "out_valid during filler", 24'(out_valid), 24'h0);
            chk(out_data == last_pkt, "R3", "out_data held", out_data, last_pkt);
        end
        flush("R3");

        // R4: marker-valued payload right after an accepted marker
        cur_req = "R4";
        do_reset();
        send_pkt(24'h123456);
        send_pkt(24'h060606);
        send_pkt(24'h000600);
        flush("R4");

        // R5: long filler gap and filler-valued payload
        cur_req = "R5";
        do_reset();
        send_pkt(24'h010203);
        for (int i = 0; i < 40; i++) send(FILL);
        send_pkt(24'hA3A3A3);
        for (int i = 0; i < 7; i++) send(8'($urandom) | 8'h80);
        flush("R5");
        send_pkt(24'h0F0E0D);
        flush("R5");

        // R6: stall cycles carrying marker values are ignored
        cur_req = "R6";
        do_reset();
        send(8'h11);
        stall(MARK);
        stall(MARK);
        send(8'h22);
        stall(MARK);
        send(8'h33);
        stall(MARK);
        expq.push_back(24'h332211);
        send(MARK);
        stall(MARK);
        stall(MARK);
        stall(MARK);
        flush("R6");

        // R7: back-to-back packets, payload often marker-valued
        cur_req = "R7";
        do_reset();
        for (int p = 0; p < 200; p++) begin
            logic [23:0] d;
            for (int k = 0; k < 3; k++)
                d[k*8 +: 8] = ($urandom_range(2) == 0) ? MARK : 8'($urandom);
            send_pkt(d);
        end
        flush("R7");

        // R8: random filler gaps, payload free of marker values
        cur_req = "R8";
        do_reset();
        for (int p = 0; p < 200; p++) begin
            int gap;
            gap = int'($urandom_range(5));
            for (int g = 0; g < gap; g++) begin
                if ($urandom_range(3) == 0) stall(MARK);
                else send(FILL);
            end
            send_pkt({rnd_nomark(), rnd_nomark(), rnd_nomark()});
        end
        flush("R8");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule